// File: doc/BRIEF.md
# CPU Control Register Unit

This unit holds the processor control registers that have side effects on other parts of the core. A read-only condition register shows the current PSW carry/condition flag. Two stack pointers are kept, one for interrupt handlers and one for user code. General register 15 is not stored in the main register file. Instead, this unit maps it onto whichever stack pointer the PSW stack-mode bit selects.

The unit also holds a backup program counter. An exception, interrupt or trap strobe loads it with either the current or the next instruction address. A return-from-exception strobe drives it back out as the resume address, aligned to a word.

Software reaches all of these registers through a control-register port. The write side of that port is clocked. The read side is combinational, so a read returns its data in the same cycle.

Top module: `cpu_ctrl_regs`

## Requirements
- R1: Reading control index 1 returns a 32-bit value whose bit 0 equals the current `psw_c` input and whose other bits are zero.
- R2: A control-register write to index 1 changes no register: both stack pointers and the backup PC keep their values.
- R3: `gr15_rdata` returns the interrupt stack pointer when `psw_sm` is 1 and the user stack pointer when it is 0. A `gr15_we` write updates only the selected pointer, at the next clock edge.
- R4: Index 2 reads and writes the interrupt stack pointer. Index 3 reads and writes the user stack pointer. Writes take effect at the next clock edge.
- R5: When `exc_evt` is 1, the backup PC is loaded at the next clock edge. It takes `pc_next` if `exc_use_next` is 1 and `pc_cur` otherwise.
- R6: Index 6 reads and writes the backup PC. Its bit 0 always reads 0, whatever value is written or captured.
- R7: While `rte_evt` is 1, `pc_restore_vld` is 1. In the same cycle, `pc_restore` equals the backup PC with bits 1:0 forced to 00.
- R8: Reading any index other than 1, 2, 3 or 6 returns zero. Writing such an index changes no register.
- R9: If an exception capture and a control write to index 6 occur in the same cycle, the capture wins.
- R10: If a control write and a register-15 write target the same stack pointer in the same cycle, the control write wins.
- R11: After reset, both stack pointers and the backup PC are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cr_we | input | 1 | Control-register write strobe |
| cr_widx | input | 5 | Control-register write index |
| cr_wdata | input | 32 | Control-register write data |
| cr_ridx | input | 5 | Control-register read index |
| cr_rdata | output | 32 | Control-register read data (combinational) |
| gr15_we | input | 1 | Register-15 write strobe |
| gr15_wdata | input | 32 | Register-15 write data |
| gr15_rdata | output | 32 | Register-15 read data (the selected stack pointer) |
| psw_c | input | 1 | PSW condition flag |
| psw_sm | input | 1 | PSW stack mode: 1 selects the interrupt stack pointer |
| exc_evt | input | 1 | Exception, interrupt or trap strobe |
| exc_use_next | input | 1 | 1 captures `pc_next`, 0 captures `pc_cur` |
| pc_cur | input | 32 | Address of the current instruction |
| pc_next | input | 32 | Address of the next instruction |
| rte_evt | input | 1 | Return-from-exception strobe |
| pc_restore | output | 32 | Word-aligned resume address |
| pc_restore_vld | output | 1 | Resume address valid |

## Verification
Random traffic mixes both write ports, both stack-mode values, all eight low indices and some out-of-range indices. This shows whether register 15 follows the mode bit or leaks into the other bank. Capture addresses have random low bits, so a dropped bit-0 clear or a missing bit-1 mask becomes visible. Directed cycles cover the cases that random traffic rarely produces:
- a write to the condition register, to check that nothing changes;
- a same-cycle collision between capture and a write to index 6;
- a same-cycle collision between a register-15 write and a control write to the same stack pointer;
- writes to unimplemented indices.

Together these separate the two priority orders from their reversed forms.

// File: rtl/cru_pkg.sv
package cru_pkg;
    parameter int CRU_XLEN  = 32;
    parameter int CRU_IDX_W = 5;

    typedef enum logic [CRU_IDX_W-1:0] {
        CRI_COND = 5'd1,
        CRI_ISP  = 5'd2,
        CRI_USP  = 5'd3,
        CRI_BKPC = 5'd6
    } cr_index_e;

    // bit count cleared from the backup PC on restore (word alignment)
    localparam int RESTORE_ALIGN = 2;
endpackage

// File: rtl/cru_stack_bank.sv
module cru_stack_bank #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sm_int,
    input  logic            cr_we_isp,
    input  logic            cr_we_usp,
    input  logic [XLEN-1:0] cr_wdata,
    input  logic            gr15_we,
    input  logic [XLEN-1:0] gr15_wdata,
    output logic [XLEN-1:0] isp_q,
    output logic [XLEN-1:0] usp_q,
    output logic [XLEN-1:0] gr15_rdata
);
    localparam int NBANK = 2;  // bank 0: interrupt, bank 1: user

    logic [XLEN-1:0] bank_q [NBANK];
    logic [NBANK-1:0] cr_sel;
    logic [NBANK-1:0] gr_sel;

    assign cr_sel = {cr_we_usp, cr_we_isp};
    assign gr_sel = {gr15_we & ~sm_int, gr15_we & sm_int};

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bank_q[b] <= '0;
            end else if (cr_sel[b]) begin
                // control port takes precedence over register 15
                bank_q[b] <= cr_wdata;
            end else if (gr_sel[b]) begin
                bank_q[b] <= gr15_wdata;
            end
        end
    end

    assign isp_q      = bank_q[0];
    assign usp_q      = bank_q[1];
    assign gr15_rdata = sm_int ? bank_q[0] : bank_q[1];
endmodule

// File: rtl/cru_backup_pc.sv
module cru_backup_pc #(
    parameter int XLEN  = 32,
    parameter int ALIGN = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            exc_evt,
    input  logic            exc_use_next,
    input  logic [XLEN-1:0] pc_cur,
    input  logic [XLEN-1:0] pc_next,
    input  logic            sw_we,
    input  logic [XLEN-1:0] sw_wdata,
    output logic [XLEN-1:0] bkpc_q,
    output logic [XLEN-1:0] restore_pc
);
    logic [XLEN-1:0] cap_val;
    logic [XLEN-1:0] nxt_val;
    logic            load;

    always_comb begin
        cap_val = exc_use_next ? pc_next : pc_cur;
        load    = exc_evt | sw_we;
        // exception capture wins over a software write
        nxt_val = exc_evt ? cap_val : sw_wdata;
        nxt_val[0] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bkpc_q <= '0;
        end else if (load) begin
            bkpc_q <= nxt_val;
        end
    end

    assign restore_pc = {bkpc_q[XLEN-1:ALIGN], {ALIGN{1'b0}}};
endmodule

// File: rtl/cru_read_mux.sv
module cru_read_mux
    import cru_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int IDX_W = 5
) (
    input  logic [IDX_W-1:0] ridx,
    input  logic             psw_c,
    input  logic [XLEN-1:0]  isp_q,
    input  logic [XLEN-1:0]  usp_q,
    input  logic [XLEN-1:0]  bkpc_q,
    output logic [XLEN-1:0]  rdata
);
    always_comb begin
        rdata = '0;
        case (ridx)
            CRI_COND: rdata = {{(XLEN-1){1'b0}}, psw_c};
            CRI_ISP:  rdata = isp_q;
            CRI_USP:  rdata = usp_q;
            CRI_BKPC: rdata = bkpc_q;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/cpu_ctrl_regs.sv
module cpu_ctrl_regs
    import cru_pkg::*;
#(
    parameter int XLEN  = CRU_XLEN,
    parameter int IDX_W = CRU_IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cr_we,
    input  logic [IDX_W-1:0] cr_widx,
    input  logic [XLEN-1:0]  cr_wdata,
    input  logic [IDX_W-1:0] cr_ridx,
    output logic [XLEN-1:0]  cr_rdata,
    input  logic             gr15_we,
    input  logic [XLEN-1:0]  gr15_wdata,
    output logic [XLEN-1:0]  gr15_rdata,
    input  logic             psw_c,
    input  logic             psw_sm,
    input  logic             exc_evt,
    input  logic             exc_use_next,
    input  logic [XLEN-1:0]  pc_cur,
    input  logic [XLEN-1:0]  pc_next,
    input  logic             rte_evt,
    output logic [XLEN-1:0]  pc_restore,
    output logic             pc_restore_vld
);
    logic            we_isp;
    logic            we_usp;
    logic            we_bkpc;
    logic [XLEN-1:0] isp_q;
    logic [XLEN-1:0] usp_q;
    logic [XLEN-1:0] bkpc_q;

    // index 1 and unimplemented indices decode to no write
    always_comb begin
        we_isp  = cr_we && (cr_widx == CRI_ISP);
        we_usp  = cr_we && (cr_widx == CRI_USP);
        we_bkpc = cr_we && (cr_widx == CRI_BKPC);
    end

    cru_stack_bank #(.XLEN(XLEN)) u_sp (
        .clk        (clk),
        .rst_n      (rst_n),
        .sm_int     (psw_sm),
        .cr_we_isp  (we_isp),
        .cr_we_usp  (we_usp),
        .cr_wdata   (cr_wdata),
        .gr15_we    (gr15_we),
        .gr15_wdata (gr15_wdata),
        .isp_q      (isp_q),
        .usp_q      (usp_q),
        .gr15_rdata (gr15_rdata)
    );

    cru_backup_pc #(.XLEN(XLEN), .ALIGN(RESTORE_ALIGN)) u_bpc (
        .clk          (clk),
        .rst_n        (rst_n),
        .exc_evt      (exc_evt),
        .exc_use_next (exc_use_next),
        .pc_cur       (pc_cur),
        .pc_next      (pc_next),
        .sw_we        (we_bkpc),
        .sw_wdata     (cr_wdata),
        .bkpc_q       (bkpc_q),
        .restore_pc   (pc_restore)
    );

    cru_read_mux #(.XLEN(XLEN), .IDX_W(IDX_W)) u_rd (
        .ridx   (cr_ridx),
        .psw_c  (psw_c),
        .isp_q  (isp_q),
        .usp_q  (usp_q),
        .bkpc_q (bkpc_q),
        .rdata  (cr_rdata)
    );

    assign pc_restore_vld = rte_evt;
endmodule

// File: rtl/cpu_ctrl_regs_chk.sv
module cpu_ctrl_regs_chk #(
    parameter int XLEN  = 32,
    parameter int IDX_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cr_we,
    input logic [IDX_W-1:0] cr_widx,
    input logic [XLEN-1:0]  cr_wdata,
    input logic [IDX_W-1:0] cr_ridx,
    input logic [XLEN-1:0]  cr_rdata,
    input logic             gr15_we,
    input logic [XLEN-1:0]  gr15_wdata,
    input logic [XLEN-1:0]  gr15_rdata,
    input logic             psw_c,
    input logic             psw_sm,
    input logic             exc_evt,
    input logic             exc_use_next,
    input logic [XLEN-1:0]  pc_cur,
    input logic [XLEN-1:0]  pc_next,
    input logic             rte_evt,
    input logic [XLEN-1:0]  pc_restore,
    input logic             pc_restore_vld,
    input logic [XLEN-1:0]  isp_q,
    input logic [XLEN-1:0]  usp_q,
    input logic [XLEN-1:0]  bkpc_q
);
    // R1
    cond_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cr_ridx == IDX_W'(1)) |-> (cr_rdata == {{(XLEN-1){1'b0}}, psw_c}));

    // R2
    cond_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cr_we && cr_widx == IDX_W'(1) && !gr15_we && !exc_evt) |=>
        (isp_q == $past(isp_q) && usp_q == $past(usp_q) && bkpc_q == $past(bkpc_q)));

    // R3
    gr15_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gr15_rdata == (psw_sm ? isp_q : usp_q));

    // R5
    exc_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_evt |=> (bkpc_q[XLEN-1:1] ==
            ($past(exc_use_next) ? $past(pc_next[XLEN-1:1]) : $past(pc_cur[XLEN-1:1]))));

    // R6
    bkpc_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bkpc_q[0] == 1'b0);

    // R7
    rte_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rte_evt |-> (pc_restore_vld && pc_restore[1:0] == 2'b00 &&
                     pc_restore[XLEN-1:2] == bkpc_q[XLEN-1:2]));

    // R10
    cr_beats_gr15_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cr_we && cr_widx == IDX_W'(2) && gr15_we && psw_sm) |=> (isp_q == $past(cr_wdata)));
endmodule

bind cpu_ctrl_regs cpu_ctrl_regs_chk #(.XLEN(XLEN), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/cpu_ctrl_regs_test.sv
`timescale 1ns/1ps
module cpu_ctrl_regs_test;
    localparam int XLEN  = 32;
    localparam int IDX_W = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cr_we = 1'b0;
    logic [IDX_W-1:0] cr_widx = '0;
    logic [XLEN-1:0]  cr_wdata = '0;
    logic [IDX_W-1:0] cr_ridx = '0;
    logic [XLEN-1:0]  cr_rdata;
    logic             gr15_we = 1'b0;
    logic [XLEN-1:0]  gr15_wdata = '0;
    logic [XLEN-1:0]  gr15_rdata;
    logic             psw_c = 1'b0;
    logic             psw_sm = 1'b0;
    logic             exc_evt = 1'b0;
    logic             exc_use_next = 1'b0;
    logic [XLEN-1:0]  pc_cur = '0;
    logic [XLEN-1:0]  pc_next = '0;
    logic             rte_evt = 1'b0;
    logic [XLEN-1:0]  pc_restore;
    logic             pc_restore_vld;

    int nchk = 0;
    int nfail = 0;
    logic [XLEN-1:0] m_isp, m_usp, m_bpc;

    always #10 clk = ~clk;  // 50 MHz

    cpu_ctrl_regs uut (.*);

    function automatic logic [XLEN-1:0] exp_read(input logic [IDX_W-1:0] idx);
        case (idx)
            5'd1:    return {{(XLEN-1){1'b0}}, psw_c};
            5'd2:    return m_isp;
            5'd3:    return m_usp;
            5'd6:    return m_bpc;
            default: return '0;
        endcase
    endfunction

    function automatic string read_tag(input logic [IDX_W-1:0] idx);
        case (idx)
            5'd1:    return "R1";
            5'd2:    return "R4";
            5'd3:    return "R4";
            5'd6:    return "R6";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_outputs();
        #1;
        check(read_tag(cr_ridx), cr_rdata, exp_read(cr_ridx));
        check("R3", gr15_rdata, psw_sm ? m_isp : m_usp);
        check("R7", {31'b0, pc_restore_vld}, {31'b0, rte_evt});
        if (rte_evt) check("R7", pc_restore, {m_bpc[XLEN-1:2], 2'b00});
    endtask

    // advance one clock edge, updating the model from the inputs driven now
    task automatic step();
        logic [XLEN-1:0] n_isp, n_usp, n_bpc;
        n_isp = m_isp; n_usp = m_usp; n_bpc = m_bpc;
        if (cr_we && cr_widx == 5'd2) n_isp = cr_wdata;
        else if (gr15_we && psw_sm) n_isp = gr15_wdata;
        if (cr_we && cr_widx == 5'd3) n_usp = cr_wdata;
        else if (gr15_we && !psw_sm) n_usp = gr15_wdata;
        if (exc_evt) n_bpc = (exc_use_next ? pc_next : pc_cur) & ~32'd1;
        else if (cr_we && cr_widx == 5'd6) n_bpc = cr_wdata & ~32'd1;
        @(posedge clk);
        m_isp = n_isp; m_usp = n_usp; m_bpc = n_bpc;
        @(negedge clk);
    endtask

    task automatic idle();
        cr_we = 0; gr15_we = 0; exc_evt = 0; rte_evt = 0;
    endtask

    task automatic read_cr(input logic [IDX_W-1:0] idx, input string tag, input logic [XLEN-1:0] exp);
        cr_ridx = idx;
        #1;
        check(tag, cr_rdata, exp);
    endtask

    initial begin
        #(20 * 150000);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk + 1, nfail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        m_isp = '0; m_usp = '0; m_bpc = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset values
        read_cr(5'd2, "R11", '0);
        read_cr(5'd3, "R11", '0);
        read_cr(5'd6, "R11", '0);

        // seed registers with known values
        cr_we = 1; cr_widx = 5'd2; cr_wdata = 32'h1111_2220; step();
        cr_widx = 5'd3; cr_wdata = 32'h3333_4440; step();
        cr_widx = 5'd6; cr_wdata = 32'h5555_6667; step();
        idle();
        read_cr(5'd6, "R6", 32'h5555_6666);

        // R2 write to the condition register changes nothing
        cr_we = 1; cr_widx = 5'd1; cr_wdata = 32'hFFFF_FFFF; step(); idle();
        read_cr(5'd2, "R2", 32'h1111_2220);
        read_cr(5'd3, "R2", 32'h3333_4440);
        read_cr(5'd6, "R2", 32'h5555_6666);
        psw_c = 1; read_cr(5'd1, "R1", 32'd1);
        psw_c = 0; read_cr(5'd1, "R1", 32'd0);

        // R8 unimplemented index writes have no effect
        cr_we = 1; cr_widx = 5'd7; cr_wdata = 32'hDEAD_BEEF; step();
        cr_widx = 5'd0; step(); cr_widx = 5'd4; step(); idle();
        read_cr(5'd2, "R8", 32'h1111_2220);
        read_cr(5'd3, "R8", 32'h3333_4440);
        read_cr(5'd6, "R8", 32'h5555_6666);
        read_cr(5'd7, "R8", 32'h0);

        // R9 capture beats software write of index 6
        cr_we = 1; cr_widx = 5'd6; cr_wdata = 32'hAAAA_0000;
        exc_evt = 1; exc_use_next = 0; pc_cur = 32'h0000_1237; pc_next = 32'h0000_123B;
        step(); idle();
        read_cr(5'd6, "R9", 32'h0000_1236);
        // R5 capture of next-instruction address
        exc_evt = 1; exc_use_next = 1; step(); idle();
        read_cr(5'd6, "R5", 32'h0000_123A);
        // R7 restore is word aligned
        rte_evt = 1; #1;
        check("R7", pc_restore, 32'h0000_1238);
        check("R7", {31'b0, pc_restore_vld}, 32'd1);
        idle();

        // R10 control write beats register-15 write on same pointer
        psw_sm = 1; gr15_we = 1; gr15_wdata = 32'h7777_0000;
        cr_we = 1; cr_widx = 5'd2; cr_wdata = 32'h8888_0000; step(); idle();
        read_cr(5'd2, "R10", 32'h8888_0000);
        psw_sm = 0; gr15_we = 1; gr15_wdata = 32'h9999_0000;
        cr_we = 1; cr_widx = 5'd3; cr_wdata = 32'hBBBB_0000; step(); idle();
        read_cr(5'd3, "R10", 32'hBBBB_0000);

        // R3 register-15 write lands only in the selected bank
        psw_sm = 1; gr15_we = 1; gr15_wdata = 32'h0C0C_0C0C; step(); idle();
        read_cr(5'd2, "R3", 32'h0C0C_0C0C);
        read_cr(5'd3, "R3", 32'hBBBB_0000);

        // random mix
        for (int i = 0; i < 600; i++) begin
            cr_we        = ($urandom % 3) == 0;
            cr_widx      = ($urandom % 4 == 0) ? IDX_W'($urandom) : IDX_W'($urandom % 8);
            cr_wdata     = $urandom;
            cr_ridx      = ($urandom % 5 == 0) ? IDX_W'($urandom) : IDX_W'($urandom % 8);
            gr15_we      = ($urandom % 3) == 0;
            gr15_wdata   = $urandom;
            psw_c        = 1'($urandom);
            psw_sm       = 1'($urandom);
            exc_evt      = ($urandom % 4) == 0;
            exc_use_next = 1'($urandom);
            pc_cur       = $urandom;
            pc_next      = $urandom;
            rte_evt      = ($urandom % 4) == 0;
            check_outputs();
            step();
        end
        idle();

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule